// File: doc/BRIEF.md
# Multiplexed Boot ROM Read Controller

This controller fetches single bytes from a parallel boot ROM that holds an 18-bit byte address space but shares one 8-bit pin group between address and data. Two external transparent-edge latches hold the upper parts of the address. On a host request the block puts the middle address byte on the shared pins and pulses a strobe. It then puts the top address byte on the same pins and pulses again. Next it releases the shared pins, drives the two lowest address bits on their own pins, enables the ROM, and samples the returned byte.

The strobe for the external latches travels on the pin that later carries address bit 1. Its rising edge loads the latches. The latches form a two-stage chain: after both strobes, the stage nearest the pins holds bits 17:10 and the next stage holds bits 9:2. Each phase length is a parameter, so latch setup and ROM access time can be matched to the clock. The host sees a one-clock completion pulse, and the fetched byte stays on its output until the next completion.

Top module: `brom_rd_ctrl`

## Requirements
- R1: During reset and right after it, `rom_ce_n` is 1, `ad_oe` is 0, `lo_addr` is 2'b00, `rd_done` is 0 and `rd_byte` is 8'h00.
- R2: An idle request is accepted on a clock edge. In the next clock the first address phase begins: for SETUP_CYC clocks `ad_oe`=1, `ad_out`=addr[9:2] and `lo_addr`=2'b00. Then for STRB_CYC clocks the same bus value is held with `lo_addr`=2'b10 (bit 1 acts as the latch strobe). `rom_ce_n` stays 1 throughout.
- R3: The second address phase follows directly with the same SETUP_CYC/STRB_CYC shape, but `ad_out`=addr[17:10].
- R4: The data phase follows for ACC_CYC clocks. In it `ad_oe`=0, `rom_ce_n`=0, and `lo_addr`=addr[1:0], held stable for the whole phase.
- R5: The value on `ad_in` in the last data-phase clock is stored. In the next clock `rd_done` is 1 for exactly one clock and `rd_byte` shows the stored value.
- R6: `rd_byte` changes only in the clock where `rd_done` is 1 and otherwise holds its value.
- R7: A request raised while a read is in flight has no effect. The running read finishes with its own address, and no second read follows.
- R8: Outside a read (idle and completion clock), `ad_oe`=0, `rom_ce_n`=1 and `lo_addr`=2'b00. The strobe bit is 1 only while `ad_oe` is 1.
- R9: Asserting `rst_n` low in the middle of a read returns all outputs to the R1 values at once, and no completion pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, sampled while idle |
| rd_addr | input | 18 | Byte address of the requested read |
| rd_done | output | 1 | One-clock completion pulse |
| rd_byte | output | 8 | Byte returned by the last completed read |
| lo_addr | output | 2 | Address bits 1:0; bit 1 doubles as latch strobe |
| ad_out | output | 8 | Value driven onto the shared address/data pins |
| ad_oe | output | 1 | Output enable for the shared pins |
| ad_in | input | 8 | Value read back from the shared pins |
| rom_ce_n | output | 1 | Active-low ROM chip enable |

## Verification
The hardest case to reach is a correct byte that depends on the two external latches holding the right halves in the right stages. That needs a ROM model that rebuilds the address only from observed pin activity. The bench models the two-stage latch chain, which shifts on each rising strobe edge, and returns a byte that is a function of that rebuilt address. A swapped, shifted or missing address byte then shows up as a wrong `rd_byte`. A second hard case is a request arriving mid-read. The bench raises one during the first address phase, with a different address, and checks that neither the pin sequence nor the result changes.

// File: rtl/brom_pkg.sv
package brom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_A1_SET, ST_A1_STB, ST_A2_SET, ST_A2_STB, ST_DATA
  } brom_st_e;

  // select the address byte carried on the shared pins in an address phase
  function automatic logic [7:0] addr_slice(input logic [17:0] a, input logic upper);
    return upper ? a[17:10] : a[9:2];
  endfunction

  function automatic logic [1:0] addr_low(input logic [17:0] a);
    return a[1:0];
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/brom_phase_timer.sv
module brom_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/brom_seq.sv
module brom_seq
  import brom_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int STRB_CYC  = 2,
  parameter int ACC_CYC   = 3,
  parameter int CW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          last,
  output brom_st_e      state,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          data_last,
  output logic          done
);
  localparam logic [CW-1:0] SET_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] STB_LD = CW'(STRB_CYC - 1);
  localparam logic [CW-1:0] ACC_LD = CW'(ACC_CYC - 1);

  brom_st_e nxt;
  logic     advance;

  assign accept    = (state == ST_IDLE) && req;
  assign advance   = (state != ST_IDLE) && last;
  assign data_last = advance && (state == ST_DATA);
  assign load      = accept || advance;

  always_comb begin
    nxt = state;
    if (accept) nxt = ST_A1_SET;
    else if (advance) begin
      case (state)
        ST_A1_SET: nxt = ST_A1_STB;
        ST_A1_STB: nxt = ST_A2_SET;
        ST_A2_SET: nxt = ST_A2_STB;
        ST_A2_STB: nxt = ST_DATA;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (nxt)
      ST_A1_STB, ST_A2_STB: load_val = STB_LD;
      ST_DATA:              load_val = ACC_LD;
      default:              load_val = SET_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= data_last;
    end
  end

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && req |=> (state != ST_A1_SET) || $past(state == ST_A1_SET)); // R7
endmodule

// File: rtl/brom_pad_drv.sv
module brom_pad_drv
  import brom_pkg::*;
(
  input  brom_st_e    state,
  input  logic [17:0] addr_q,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [1:0]  lo_addr,
  output logic        rom_ce_n
);
  logic upper_half;
  logic strobe;

  assign upper_half = (state == ST_A2_SET) || (state == ST_A2_STB);
  assign strobe     = (state == ST_A1_STB) || (state == ST_A2_STB);
  assign ad_oe      = (state != ST_IDLE) && (state != ST_DATA);
  assign ad_out     = ad_oe ? addr_slice(addr_q, upper_half) : 8'h00;
  assign rom_ce_n   = (state != ST_DATA);

  always_comb begin
    if (state == ST_DATA) lo_addr = addr_low(addr_q);
    else                  lo_addr = {strobe, 1'b0};
  end
endmodule

// File: rtl/brom_rd_ctrl.sv
module brom_rd_ctrl
  import brom_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int STRB_CYC  = 2,
  parameter int ACC_CYC   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [17:0] rd_addr,
  output logic        rd_done,
  output logic [7:0]  rd_byte,
  output logic [1:0]  lo_addr,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic        rom_ce_n
);
  localparam int MAXC = max3(SETUP_CYC, STRB_CYC, ACC_CYC);
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  brom_st_e      state;
  logic          load, last, accept, data_last;
  logic [CW-1:0] load_val;
  logic [17:0]   addr_q;

  brom_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
  );

  brom_seq #(
    .SETUP_CYC(SETUP_CYC), .STRB_CYC(STRB_CYC), .ACC_CYC(ACC_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .last(last), .state(state),
    .load(load), .load_val(load_val), .accept(accept), .data_last(data_last),
    .done(rd_done)
  );

  brom_pad_drv u_pads (
    .state(state), .addr_q(addr_q), .ad_out(ad_out), .ad_oe(ad_oe),
    .lo_addr(lo_addr), .rom_ce_n(rom_ce_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_byte <= '0;
    end else begin
      if (accept)    addr_q  <= rd_addr;
      if (data_last) rd_byte <= ad_in;
    end
  end

  AST_BUS_FREE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> !ad_oe); // R4
  AST_LOW_BITS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n && $past(!rom_ce_n) |-> $stable(lo_addr)); // R4
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_byte) |-> rd_done); // R6
  AST_STROBE_WITH_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    lo_addr[1] && rom_ce_n |-> ad_oe); // R8
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce_n && !ad_oe |-> lo_addr == 2'b00); // R8
endmodule

// File: tb/brom_rd_ctrl_tb_top.sv
module brom_rd_ctrl_tb_top;
  localparam int SC  = 2;
  localparam int PC  = 3;
  localparam int AC  = 4;
  localparam int TOT = 2*SC + 2*PC + AC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [17:0] rd_addr = '0;
  logic        rd_done;
  logic [7:0]  rd_byte;
  logic [1:0]  lo_addr;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic        rom_ce_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  brom_rd_ctrl #(.SETUP_CYC(SC), .STRB_CYC(PC), .ACC_CYC(AC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_byte(rd_byte), .lo_addr(lo_addr), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .rom_ce_n(rom_ce_n)
  );

  // ROM content: any address-dependent byte pattern
  function automatic logic [7:0] rom_val(input logic [17:0] a);
    return a[7:0] ^ {a[12:8], a[17:15]} ^ {6'b0, a[14:13]} ^ 8'h3C;
  endfunction

  // two cascaded external latches, loaded on each rising strobe edge
  logic [7:0] lat_near = '0;
  logic [7:0] lat_far  = '0;
  always @(posedge lo_addr[1]) begin
    if (rom_ce_n) begin
      lat_far  <= lat_near;
      lat_near <= ad_out;
    end
  end
  assign ad_in = (!rom_ce_n && !ad_oe) ? rom_val({lat_near, lat_far, lo_addr}) : 8'hEE;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string rq);
    chk(rq, "ce_n", 32'(rom_ce_n), 1);
    chk(rq, "oe", 32'(ad_oe), 0);
    chk(rq, "lo", 32'(lo_addr), 0);
    chk(rq, "done", 32'(rd_done), 0);
  endtask

  // one full read; optionally raise a competing request mid-read (R7)
  task automatic do_read(input logic [17:0] a, input bit intrude);
    logic [7:0] exp_b;
    exp_b = rom_val(a);
    @(negedge clk); rd_req = 1'b1; rd_addr = a;
    @(negedge clk); rd_req = 1'b0;
    for (int i = 0; i <= TOT; i++) begin
      if (i < SC) begin
        chk("R2", "a1 oe", 32'(ad_oe), 1);
        chk("R2", "a1 bus", 32'(ad_out), 32'(a[9:2]));
        chk("R2", "a1 lo", 32'(lo_addr), 0);
        chk("R2", "a1 ce", 32'(rom_ce_n), 1);
      end else if (i < SC + PC) begin
        chk("R2", "a1s bus", 32'(ad_out), 32'(a[9:2]));
        chk("R2", "a1s lo", 32'(lo_addr), 2);
        chk("R2", "a1s oe", 32'(ad_oe), 1);
      end else if (i < 2*SC + PC) begin
        chk("R3", "a2 bus", 32'(ad_out), 32'(a[17:10]));
        chk("R3", "a2 lo", 32'(lo_addr), 0);
        chk("R3", "a2 ce", 32'(rom_ce_n), 1);
      end else if (i < 2*SC + 2*PC) begin
        chk("R3", "a2s bus", 32'(ad_out), 32'(a[17:10]));
        chk("R3", "a2s lo", 32'(lo_addr), 2);
        chk("R3", "a2s oe", 32'(ad_oe), 1);
      end else if (i < TOT) begin
        chk("R4", "d oe", 32'(ad_oe), 0);
        chk("R4", "d ce", 32'(rom_ce_n), 0);
        chk("R4", "d lo", 32'(lo_addr), 32'(a[1:0]));
        chk("R5", "d done", 32'(rd_done), 0);
      end else begin
        chk("R5", "done", 32'(rd_done), 1);
        chk("R5", "byte", 32'(rd_byte), 32'(exp_b));
        chk("R8", "end ce", 32'(rom_ce_n), 1);
      end
      if (intrude && i == 1) begin
        rd_req = 1'b1; rd_addr = ~a;
      end else begin
        rd_req = 1'b0;
      end
      @(negedge clk);
    end
    rd_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk_idle(intrude ? "R7" : "R8");
      chk("R6", "byte held", 32'(rd_byte), 32'(exp_b));
      @(negedge clk);
    end
  endtask

  task automatic test_reset;
    chk_idle("R1");
    chk("R1", "byte", 32'(rd_byte), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    chk("R1", "byte", 32'(rd_byte), 0);
  endtask

  task automatic test_mid_reset;
    @(negedge clk); rd_req = 1'b1; rd_addr = 18'h2A5C3;
    @(negedge clk); rd_req = 1'b0;
    repeat (2*SC + 2*PC + 1) @(negedge clk);
    chk("R9", "in data", 32'(rom_ce_n), 0);
    rst_n = 1'b0;
    #1;
    chk_idle("R9");
    chk("R9", "byte", 32'(rd_byte), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < TOT + 2; k++) begin
      @(negedge clk);
      chk_idle("R9");
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    do_read(18'h00000, 1'b0);
    do_read(18'h3FFFF, 1'b0);
    do_read(18'h15A96, 1'b0);
    do_read(18'h2C3E1, 1'b0);
    do_read(18'h0F00E, 1'b1);
    do_read(18'h30C07, 1'b0);
    test_mid_reset();
    do_read(18'h1B2D4, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule